// File: doc/BRIEF.md
# Two-Level Grouped Priority Arbiter

This block arbitrates among three requesters that share one narrow transfer path. Requesters 0 and 1 form the paired group; requester 2 stands alone as the single group. Each level can run in one of two ways. It can use fixed priority, where a configured member or group always wins a contest. It can also use round robin, where the last one served yields to the other.

A registered one-hot grant is issued one clock after arbitration. It stays in place until the grantee's transfer completes, and the bench signals each narrow beat with a one-cycle `beat_done` strobe. In per-beat mode the grant is released and re-arbitrated on every beat. In per-word mode it is released only after a full 32-bit word has been moved. That takes four byte beats, or two halfword beats when `cfg_half` is set. One instance is placed per bus, and each instance has its own configuration inputs.

Top module: `grp_arb`

## Requirements
- R1: During and right after reset, `gnt` is 3'b000. Round-robin state starts so that member 0 is preferred inside the paired group and the paired group is preferred over requester 2.
- R2: `gnt` is always zero or one-hot (bit i grants requester i). A newly issued grant goes only to a requester whose `req` bit was high in the cycle before.
- R3: When `req` is all zero, no grant is issued. Idle cycles leave the round-robin preference unchanged.
- R4: When `cfg_pair_rr`=0, a contest between requesters 0 and 1 is won by the member given by `cfg_pair_fix` (0 selects requester 0, 1 selects requester 1).
- R5: When `cfg_pair_rr`=1, a contest between requesters 0 and 1 goes to the member not served by the last completed grant in that group.
- R6: When `cfg_grp_rr`=0, a contest between the groups is won by the group given by `cfg_grp_fix` (0 selects the pair, 1 selects requester 2).
- R7: When `cfg_grp_rr`=1, a contest between the groups goes to the group not served by the last completed grant.
- R8: When `cfg_word`=0, every `beat_done` while a grant is held releases it. New arbitration happens on that same edge, so the next grant shows one clock after the strobe.
- R9: When `cfg_word`=1, the grant is released on the 4th `beat_done` if `cfg_half`=0, or on the 2nd if `cfg_half`=1.
- R10: While a grant is held, it does not change because of a request from a higher-priority requester.
- R11: A `beat_done` that arrives while no grant is held has no effect and does not count toward a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 3 | Request lines, one per requester |
| beat_done | input | 1 | One narrow transfer of the grantee finished |
| cfg_pair_rr | input | 1 | Paired group uses round robin |
| cfg_pair_fix | input | 1 | Fixed winner inside the pair |
| cfg_grp_rr | input | 1 | Group level uses round robin |
| cfg_grp_fix | input | 1 | Fixed winning group |
| cfg_word | input | 1 | Hold the grant for a whole word |
| cfg_half | input | 1 | Beats are halfwords (2 per word) instead of bytes (4 per word) |
| gnt | output | 3 | Registered one-hot grant |

## Verification
The hardest case to reach is the interaction between word-mode hold, round-robin state and strobes that arrive with no grant. It requires a pointer that was moved by a completed grant, then idle cycles, then a request from the competitor that lost the last round. Each directed scenario starts from reset, so the starting preference is known. Strobes are fired while nothing is granted, and then enough strobes follow to show exactly which beat ends the word. Higher-priority requests are raised in the middle of a word to show that the hold is not broken.

// File: rtl/grp_arb.sv
module grp_arb #(
  parameter int NREQ = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            beat_done,
  input  logic            cfg_pair_rr,
  input  logic            cfg_pair_fix,
  input  logic            cfg_grp_rr,
  input  logic            cfg_grp_fix,
  input  logic            cfg_word,
  input  logic            cfg_half,
  output logic [NREQ-1:0] gnt
);
  logic [1:0] beat_cnt;
  logic       last_pair;
  logic       last_grp;

  logic       busy, release_now, arb_now;
  logic [1:0] beat_last;
  logic       pair_eff, grp_eff;
  logic       pair_pref, grp_pref;
  logic       pair_any, pair_pick;
  logic [NREQ-1:0] win;

  assign busy        = |gnt;
  assign beat_last   = cfg_half ? 2'd1 : 2'd3;
  assign release_now = busy && beat_done && (!cfg_word || beat_cnt == beat_last);
  assign arb_now     = !busy || release_now;

  assign pair_eff = (release_now && (gnt[0] || gnt[1])) ? gnt[1] : last_pair;
  assign grp_eff  = release_now ? gnt[2] : last_grp;

  assign pair_pref = cfg_pair_rr ? ~pair_eff : cfg_pair_fix;
  assign grp_pref  = cfg_grp_rr  ? ~grp_eff  : cfg_grp_fix;

  assign pair_any  = req[0] | req[1];
  assign pair_pick = req[pair_pref] ? pair_pref : ~pair_pref;

  always_comb begin
    win = '0;
    if (pair_any && (!req[2] || !grp_pref))
      win[pair_pick] = 1'b1;
    else if (req[2])
      win[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt       <= '0;
      beat_cnt  <= '0;
      last_pair <= 1'b1;
      last_grp  <= 1'b1;
    end else begin
      if (arb_now) begin
        gnt      <= win;
        beat_cnt <= '0;
      end else if (beat_done) begin
        beat_cnt <= beat_cnt + 2'd1;
      end
      if (release_now) begin
        last_grp <= gnt[2];
        if (gnt[0] || gnt[1]) last_pair <= gnt[1];
      end
    end
  end
endmodule

// File: rtl/grp_arb_chk.sv
module grp_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] req,
  input logic       beat_done,
  input logic       cfg_word,
  input logic [2:0] gnt
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  p_grant_to_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 3'b000 && req != 3'b000) |=> ((gnt & $past(req)) != 3'b000));

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 3'b000 && req == 3'b000) |=> gnt == 3'b000);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 3'b000 && !beat_done) |=> $stable(gnt));

  p_beat_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 3'b000 && beat_done && !cfg_word && req == 3'b000) |=> gnt == 3'b000);
endmodule

bind grp_arb grp_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .beat_done(beat_done),
  .cfg_word(cfg_word), .gnt(gnt)
);

// File: tb/grp_arb_tb.sv
module grp_arb_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] req;
  logic       beat_done;
  logic       cfg_pair_rr, cfg_pair_fix, cfg_grp_rr, cfg_grp_fix, cfg_word, cfg_half;
  logic [2:0] gnt;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_arb u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .beat_done(beat_done),
    .cfg_pair_rr(cfg_pair_rr), .cfg_pair_fix(cfg_pair_fix),
    .cfg_grp_rr(cfg_grp_rr), .cfg_grp_fix(cfg_grp_fix),
    .cfg_word(cfg_word), .cfg_half(cfg_half), .gnt(gnt)
  );

  task automatic chk(input logic [2:0] exp, input string tag);
    n_chk++;
    if (gnt !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt=%b expected=%b", tag, gnt, exp);
    end
  endtask

  // apply inputs after a falling edge; they take effect at the next rising edge
  task automatic step(input logic [2:0] r, input logic b);
    req = r; beat_done = b;
    @(negedge clk);
    beat_done = 1'b0;
  endtask

  task automatic do_reset(input logic prr, pfx, grr, gfx, wd, hf);
    cfg_pair_rr = prr; cfg_pair_fix = pfx; cfg_grp_rr = grr; cfg_grp_fix = gfx;
    cfg_word = wd; cfg_half = hf;
    req = '0; beat_done = 1'b0; rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(3'b000, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_fixed_pair;
    do_reset(0, 1, 0, 0, 0, 0);
    step(3'b011, 0); chk(3'b010, "R4 fixed member 1 wins");
    step(3'b011, 1); chk(3'b010, "R8 rearb keeps fixed winner");
    step(3'b001, 1); chk(3'b001, "R8 release each beat");
    step(3'b000, 1); chk(3'b000, "R8 release to idle");
  endtask

  task automatic t_rr_pair;
    do_reset(1, 0, 0, 0, 0, 0);
    step(3'b011, 0); chk(3'b001, "R1 pair starts at 0");
    step(3'b011, 1); chk(3'b010, "R5 rr alternates to 1");
    step(3'b011, 1); chk(3'b001, "R5 rr alternates to 0");
  endtask

  task automatic t_fixed_grp;
    do_reset(0, 0, 0, 1, 0, 0);
    step(3'b101, 0); chk(3'b100, "R6 fixed group picks 2");
    step(3'b101, 1); chk(3'b100, "R6 fixed group again");
  endtask

  task automatic t_rr_grp;
    do_reset(0, 0, 1, 0, 0, 0);
    step(3'b101, 0); chk(3'b001, "R1 pair group first");
    step(3'b101, 1); chk(3'b100, "R7 rr to group 2");
    step(3'b101, 1); chk(3'b001, "R7 rr back to pair");
  endtask

  task automatic t_word_byte_hold;
    do_reset(0, 0, 0, 0, 1, 0);
    step(3'b100, 0); chk(3'b100, "R9 grant 2");
    for (int i = 0; i < 3; i++) begin
      step(3'b101, 1); chk(3'b100, "R10 held vs higher priority");
    end
    step(3'b101, 1); chk(3'b001, "R9 released on 4th byte beat");
  endtask

  task automatic t_word_half;
    do_reset(1, 0, 0, 0, 1, 1);
    step(3'b011, 0); chk(3'b001, "R9 half grant 0");
    step(3'b011, 1); chk(3'b001, "R9 held after 1st half beat");
    step(3'b011, 1); chk(3'b010, "R9 released on 2nd half beat");
  endtask

  task automatic t_idle_holds;
    do_reset(1, 0, 0, 0, 0, 0);
    step(3'b001, 0); chk(3'b001, "R3 grant 0");
    step(3'b000, 1); chk(3'b000, "R3 no request no grant");
    for (int i = 0; i < 4; i++) begin
      step(3'b000, 0); chk(3'b000, "R3 idle");
    end
    step(3'b011, 0); chk(3'b010, "R3 rr state kept over idle");
  endtask

  task automatic t_stray_beats;
    do_reset(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) begin
      step(3'b000, 1); chk(3'b000, "R11 stray beat no grant");
    end
    step(3'b100, 0); chk(3'b100, "R11 grant 2");
    for (int i = 0; i < 3; i++) begin
      step(3'b000, 1); chk(3'b100, "R11 stray beats not counted");
    end
    step(3'b000, 1); chk(3'b000, "R11 release on 4th real beat");
  endtask

  initial begin
    fork
      begin
        t_fixed_pair();
        t_rr_pair();
        t_fixed_grp();
        t_rr_grp();
        t_word_byte_hold();
        t_word_half();
        t_idle_holds();
        t_stray_beats();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule